// File: doc/BRIEF.md
# Signed Array Multiplier (Baugh-Wooley form)

This block multiplies two two's-complement operands of `WIDTH` bits and returns their exact two's-complement product of `2*WIDTH` bits. It has no clock and no state: the product follows the operands through combinational logic. With the default width of 4, two signed 4-bit values produce a signed 8-bit result.

Each pair of operand bits forms a partial-product bit through an AND cell. The terms that combine exactly one sign bit with one magnitude bit are complemented. Two constant ones are injected, one at weight `WIDTH` and one at weight `2*WIDTH-1`. Together these replace any sign extension or operand recoding.

The bits are summed in a regular array of full-adder cells. There are `WIDTH-1` carry-save rows followed by one ripple stage. Each carry moves diagonally into the next row at the same column index. With the default width the array uses 15 full adders, since the count is `WIDTH*WIDTH-1`. The top product bit is a complemented XOR, because its correction one needs no adder of its own. The result is defined only for signed operands.

Top module: `bw_signed_mult`

## Requirements
- R1: For every pair of signed operands, `prod` equals the exact two's-complement product of `a_op` and `b_op`, taken over the full `2*WIDTH`-bit range.
- R2: When either operand is zero, `prod` is zero in all `2*WIDTH` bits.
- R3: When both operands are the most negative value (-8 at the default width), `prod` is +2^(2*WIDTH-2) (+64). Only bit `2*WIDTH-2` is set, so no overflow occurs.
- R4: When one operand is the most negative value and the other is the most positive value, the result is the negative of their magnitude product. At the default width -8 × 7 gives -56, which is 8'hC8.
- R5: When both operands are nonzero, the top bit of `prod` equals the XOR of the operands' top bits.
- R6: When one operand is +1, `prod` is the other operand sign-extended to `2*WIDTH` bits.
- R7: Swapping the two operands leaves `prod` unchanged.
- R8: When one operand is -1 (all ones), `prod` is the two's-complement negation of the other operand in `2*WIDTH` bits. For the most negative operand this gives +2^(WIDTH-1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_op | input | WIDTH | Multiplicand, two's complement |
| b_op | input | WIDTH | Multiplier, two's complement |
| prod | output | 2*WIDTH | Signed product, two's complement |

## Verification
The bench builds the block twice: at the default width of 4 and at a width of 6. At width 4 every one of the 256 operand pairs is swept, so the correction constants and the diagonal carry paths are covered completely. At width 6 a fixed-seed random sample is run together with the directed extremes. This shows that the generated array and the correction positions scale with the parameter, and that the results are not just correct for one fixed size.

// File: rtl/bw_mult_pkg.sv
package bw_mult_pkg;

    // Structural cell counts for a given operand width
    function automatic int unsigned fa_cells(input int unsigned w);
        return w * w - 1;
    endfunction

    function automatic int unsigned inv_cells(input int unsigned w);
        return 2 * (w - 1) + 1;
    endfunction

    // True when partial product (row, col) must be complemented:
    // exactly one of its indices addresses the sign bit
    function automatic logic pp_flip(input int unsigned row,
                                     input int unsigned col,
                                     input int unsigned w);
        return (row == w - 1) ^ (col == w - 1);
    endfunction

    typedef struct packed {
        logic sum;
        logic cry;
    } fa_out_t;

endpackage

// File: rtl/bw_full_adder.sv
module bw_full_adder
    import bw_mult_pkg::*;
(
    input  logic    x_in,
    input  logic    y_in,
    input  logic    c_in,
    output fa_out_t res
);
    assign res.sum = x_in ^ y_in ^ c_in;
    assign res.cry = (x_in & y_in) | (x_in & c_in) | (y_in & c_in);
endmodule

// File: rtl/bw_pp_gen.sv
module bw_pp_gen
    import bw_mult_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0]            a_op,
    input  logic [WIDTH-1:0]            b_op,
    output logic [WIDTH-1:0][WIDTH-1:0] pp      // pp[row][col], weight row+col
);
    for (genvar r = 0; r < WIDTH; r++) begin : g_row
        for (genvar c = 0; c < WIDTH; c++) begin : g_col
            logic and_bit;
            assign and_bit = b_op[r] & a_op[c];
            if (pp_flip(r, c, WIDTH)) begin : g_inv
                assign pp[r][c] = ~and_bit;
            end else begin : g_pass
                assign pp[r][c] = and_bit;
            end
        end
    end
endmodule

// File: rtl/bw_adder_array.sv
module bw_adder_array
    import bw_mult_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0][WIDTH-1:0] pp,
    output logic [2*WIDTH-1:0]          prod
);
    localparam int unsigned TOP = 2 * WIDTH - 1;

    logic [WIDTH-1:0][WIDTH-1:0] sum_r;   // sum_r[row][col], weight row+col
    logic [WIDTH-1:0][WIDTH-1:0] cry_r;   // cry_r[row][col], weight row+col+1
    logic [WIDTH-1:0]            rip;     // ripple carries of the last stage

    // Row 0: partial products pass straight through, no carries
    assign sum_r[0] = pp[0];
    assign cry_r[0] = '0;

    // Carry-save rows: each carry drops diagonally into the next row
    for (genvar r = 1; r < WIDTH; r++) begin : g_csa_row
        for (genvar c = 0; c < WIDTH; c++) begin : g_csa_col
            logic    upper;
            fa_out_t fo;
            if (c < WIDTH - 1) begin : g_mid
                assign upper = sum_r[r-1][c+1];
            end else begin : g_edge
                assign upper = 1'b0;
            end
            bw_full_adder u_fa (
                .x_in (pp[r][c]),
                .y_in (upper),
                .c_in (cry_r[r-1][c]),
                .res  (fo)
            );
            assign sum_r[r][c] = fo.sum;
            assign cry_r[r][c] = fo.cry;
        end
    end

    // Low half of the product leaves from column 0 of each row
    for (genvar r = 0; r < WIDTH; r++) begin : g_low
        assign prod[r] = sum_r[r][0];
    end

    // Final ripple stage; the weight-WIDTH correction one enters as carry-in
    assign rip[0] = 1'b1;
    for (genvar k = 0; k < WIDTH - 1; k++) begin : g_ripple
        fa_out_t fo;
        bw_full_adder u_fa (
            .x_in (sum_r[WIDTH-1][k+1]),
            .y_in (cry_r[WIDTH-1][k]),
            .c_in (rip[k]),
            .res  (fo)
        );
        assign prod[WIDTH+k] = fo.sum;
        assign rip[k+1]      = fo.cry;
    end

    // Top weight: correction one folded in as a complement, carry dropped
    assign prod[TOP] = ~(cry_r[WIDTH-1][WIDTH-1] ^ rip[WIDTH-1]);
endmodule

// File: rtl/bw_signed_mult.sv
module bw_signed_mult
    import bw_mult_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0]   a_op,
    input  logic [WIDTH-1:0]   b_op,
    output logic [2*WIDTH-1:0] prod
);
    localparam int unsigned N_FA  = fa_cells(WIDTH);
    localparam int unsigned N_INV = inv_cells(WIDTH);

    logic [WIDTH-1:0][WIDTH-1:0] pp;

    initial begin
        if (WIDTH < 2) $error("bw_signed_mult: WIDTH must be at least 2");
        if (N_FA == 0 || N_INV == 0) $error("bw_signed_mult: bad cell counts");
    end

    bw_pp_gen #(.WIDTH(WIDTH)) u_pp (
        .a_op (a_op),
        .b_op (b_op),
        .pp   (pp)
    );

    bw_adder_array #(.WIDTH(WIDTH)) u_arr (
        .pp   (pp),
        .prod (prod)
    );
endmodule

// File: rtl/bw_signed_mult_chk.sv
module bw_signed_mult_chk #(
    parameter int unsigned WIDTH = 4
) (
    input logic [WIDTH-1:0]   a_op,
    input logic [WIDTH-1:0]   b_op,
    input logic [2*WIDTH-1:0] prod
);
    localparam int unsigned PW = 2 * WIDTH;

    logic signed [PW-1:0] a_ext, b_ext, ref_p;
    logic [WIDTH-1:0]     min_val;

    always_comb begin
        a_ext   = PW'($signed(a_op));
        b_ext   = PW'($signed(b_op));
        ref_p   = a_ext * b_ext;
        min_val = {1'b1, {(WIDTH-1){1'b0}}};

        p_exact_r1: assert (prod == ref_p)
            else $error("R1 product mismatch");
        p_zero_r2: assert (!((a_op == '0) || (b_op == '0)) || (prod == '0))
            else $error("R2 zero operand");
        p_minsq_r3: assert (!((a_op == min_val) && (b_op == min_val))
                            || $onehot0(prod) && prod[PW-2])
            else $error("R3 min squared");
        p_sign_r5: assert (!((a_op != '0) && (b_op != '0))
                           || (prod[PW-1] == (a_op[WIDTH-1] ^ b_op[WIDTH-1])))
            else $error("R5 sign");
        p_unit_r6: assert (!(a_op == WIDTH'(1)) || (prod == b_ext))
            else $error("R6 unit operand");
    end
endmodule

bind bw_signed_mult bw_signed_mult_chk #(.WIDTH(WIDTH)) u_chk (
    .a_op (a_op),
    .b_op (b_op),
    .prod (prod)
);

// File: tb/tb_bw_signed_mult.sv
module tb_bw_signed_mult;
    localparam int W4 = 4;
    localparam int W6 = 6;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [W4-1:0]   a4, b4;
    logic [2*W4-1:0] p4;
    logic [W6-1:0]   a6, b6;
    logic [2*W6-1:0] p6;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;

    bw_signed_mult #(.WIDTH(W4)) dut   (.a_op(a4), .b_op(b4), .prod(p4));
    bw_signed_mult #(.WIDTH(W6)) dut_w6(.a_op(a6), .b_op(b6), .prod(p6));

    function automatic logic [2*W4-1:0] exp4(input logic [W4-1:0] x, input logic [W4-1:0] y);
        int sx, sy;
        sx = int'($signed(x));
        sy = int'($signed(y));
        return (2*W4)'(sx * sy);
    endfunction

    function automatic logic [2*W6-1:0] exp6(input logic [W6-1:0] x, input logic [W6-1:0] y);
        int sx, sy;
        sx = int'($signed(x));
        sy = int'($signed(y));
        return (2*W6)'(sx * sy);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic drive4(input logic [W4-1:0] x, input logic [W4-1:0] y);
        a4 = x; b4 = y;
        @(negedge clk);
    endtask

    task automatic drive6(input logic [W6-1:0] x, input logic [W6-1:0] y);
        a6 = x; b6 = y;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [2*W4-1:0] first;
        a4 = '0; b4 = '0; a6 = '0; b6 = '0;
        @(negedge clk);
        chk("R2 idle zero", 32'(p4), 32'(0));

        // R1 exhaustive sweep at width 4
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                drive4(W4'(i), W4'(j));
                chk("R1 sweep", 32'(p4), 32'(exp4(W4'(i), W4'(j))));
            end
        end

        // R2 zero operand
        drive4(4'h0, 4'h9); chk("R2 a zero", 32'(p4), 32'(0));
        drive4(4'h8, 4'h0); chk("R2 b zero", 32'(p4), 32'(0));
        // R3 most negative squared
        drive4(4'h8, 4'h8); chk("R3 -8*-8", 32'(p4), 32'(8'h40));
        // R4 mixed extremes
        drive4(4'h8, 4'h7); chk("R4 -8*7", 32'(p4), 32'(8'hC8));
        drive4(4'h7, 4'h8); chk("R4 7*-8", 32'(p4), 32'(8'hC8));
        // R5 sign of nonzero products
        drive4(4'hD, 4'h3); chk("R5 neg*pos", 32'(p4[7]), 32'(1));
        drive4(4'hD, 4'hB); chk("R5 neg*neg", 32'(p4[7]), 32'(0));
        // R6 unit operand
        drive4(4'h1, 4'hA); chk("R6 1*-6", 32'(p4), 32'(8'hFA));
        drive4(4'h5, 4'h1); chk("R6 5*1", 32'(p4), 32'(8'h05));
        // R8 minus one
        drive4(4'hF, 4'h8); chk("R8 -1*-8", 32'(p4), 32'(8'h08));
        drive4(4'h3, 4'hF); chk("R8 3*-1", 32'(p4), 32'(8'hFD));

        // R7 commutation over random pairs, fixed seed
        void'($urandom(32'h5EED_0042));
        for (int n = 0; n < 64; n++) begin
            logic [W4-1:0] x, y;
            x = W4'($urandom);
            y = W4'($urandom);
            drive4(x, y); first = p4;
            drive4(y, x);
            chk("R7 swap", 32'(p4), 32'(first));
        end

        // Width 6: directed extremes and random sample
        drive6(6'h20, 6'h20); chk("R3 w6 min sq", 32'(p6), 32'(12'h400));
        drive6(6'h20, 6'h1F); chk("R4 w6 min*max", 32'(p6), 32'(exp6(6'h20, 6'h1F)));
        drive6(6'h00, 6'h2A); chk("R2 w6 zero", 32'(p6), 32'(0));
        drive6(6'h3F, 6'h20); chk("R8 w6 -1*min", 32'(p6), 32'(12'h020));
        for (int n = 0; n < 2000; n++) begin
            logic [W6-1:0] x, y;
            x = W6'($urandom);
            y = W6'($urandom);
            drive6(x, y);
            chk("R1 w6 random", 32'(p6), 32'(exp6(x, y)));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule